// File: doc/BRIEF.md
# Board Management Register Bank with Serial Target Port

This block lets a host processor reach a small set of 8-bit board-management registers over a four-wire serial link. Through it the host drives four indicator LEDs and sets a group of reset, power-enable and module-control bytes. It also reads the live state of pushbuttons and DIP switches, three power-good status bytes and an externally selected bus-master code. Every change on a button or switch input is caught in a sticky flag that stays set until the host clears it. A guarded warm-reset command only produces a pulse when a key register has been armed first.

All logic runs on one system clock `clk`. The serial inputs are oversampled through synchronizers, so the serial clock must be several times slower than `clk`. Each access is one transaction framed by chip select, made of an address byte followed by a data byte. The least significant address bit selects the direction, and address bits 7:1 pick the register.

Top module: `board_ctl_spi`

## Requirements
- R1: Serial bits are sampled on rising edges of `sclk` while `cs_n` is low, most significant bit first. The first byte is the address and the second is data. Address bit 0 set to 1 means read and 0 means write, and the register index is address bits 7:1.
- R2: On a read, `miso` changes on the falling `sclk` edges of the second byte and carries the register value MSB first. `miso` stays low during the address byte and while `cs_n` is high.
- R3: Index 0 (address 0x00/0x01) reads the parameter `VERSION` (default 0x13). Writes to it change nothing.
- R4: Index 1 (0x02/0x03) is the LED register. Write data bits 7:4 drive `led_o[3:0]`, and a read returns those four bits in 7:4 with zeros in 3:0.
- R5: Index 2 (0x04/0x05) reads the synchronized `btn_sw_i` byte. Writes to it are ignored.
- R6: Index 3 (0x06/0x07) holds one sticky flag per `btn_sw_i` bit. A flag is set by either edge of its synchronized input. Writing 1 to a bit clears that flag and writing 0 leaves it alone. When a set and a clear meet in the same cycle, the flag stays set. No flag is set by the input settling after reset.
- R7: Indices 4, 5 and 6 (0x08, 0x0A, 0x0C) read `pwr_good_i` bytes 0, 1 and 2. Index 12 (0x18) reads `mux_sel_i`. Writes to all of them are ignored.
- R8: Indices 7, 8, 9, 10, 11 and 15 (0x0E, 0x10, 0x12, 0x14, 0x16, 0x1E) are read/write control bytes that appear on `ctl_o` bytes 0 to 5 in that order. They are 0 after reset.
- R9: Index 14 (0x1C) is a read/write key. A write to index 13 (0x1A) raises `warm_rst_o` for exactly one `clk` cycle only if the key equals `WARM_KEY` (default 0xA5). Every write to index 13 clears the key, and index 13 reads 0x00.
- R10: Indices 16 and above read 0x00, and writes to them change no output or register.
- R11: Raising `cs_n` before the 16th rising `sclk` edge abandons the transaction, and no register changes.
- R12: While `rst` is high and after its release, `led_o`, `ctl_o`, `warm_rst_o` and `miso` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Serial chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| led_o | output | 4 | LED drive |
| btn_sw_i | input | 8 | Pushbutton and DIP-switch levels |
| pwr_good_i | input | 24 | Three power-good status bytes |
| mux_sel_i | input | 8 | Bus-master select code |
| ctl_o | output | 48 | Six control bytes |
| warm_rst_o | output | 1 | Guarded warm-reset pulse |

## Verification
The guarded warm-reset path is the hardest part to reach from the ports. A pulse needs the key written and then the command, in two separate transactions, and several other paths must be shown to produce no pulse: the command without a key, a second command with the key already consumed, and a wrong key. The stimulus also cuts one transaction off after twelve bits to show that a partly shifted data byte is discarded. It toggles single switch inputs between transactions to show that a flag survives a zero-valued clear write and drops only on a matching 1.

// File: rtl/brd_pkg.sv
package brd_pkg;

    localparam int REG_W   = 8;
    localparam int NUM_CTL = 6;

    typedef logic [REG_W-1:0] byte_t;
    typedef logic [6:0]       reg_ix_t;

    localparam reg_ix_t IX_VER  = 7'd0;
    localparam reg_ix_t IX_LED  = 7'd1;
    localparam reg_ix_t IX_BTN  = 7'd2;
    localparam reg_ix_t IX_FLG  = 7'd3;
    localparam reg_ix_t IX_PG0  = 7'd4;
    localparam reg_ix_t IX_PG1  = 7'd5;
    localparam reg_ix_t IX_PG2  = 7'd6;
    localparam reg_ix_t IX_MEZ  = 7'd7;
    localparam reg_ix_t IX_CPUR = 7'd8;
    localparam reg_ix_t IX_PERR = 7'd9;
    localparam reg_ix_t IX_OPTA = 7'd10;
    localparam reg_ix_t IX_OPTB = 7'd11;
    localparam reg_ix_t IX_MSEL = 7'd12;
    localparam reg_ix_t IX_WARM = 7'd13;
    localparam reg_ix_t IX_KEY  = 7'd14;
    localparam reg_ix_t IX_PMB  = 7'd15;

    typedef enum logic [1:0] {PH_ADDR, PH_DATA, PH_DONE} spi_phase_e;

    typedef struct packed {
        reg_ix_t ix;
        byte_t   data;
    } wr_req_t;

    // Slot of a plain control byte on the ctl output, -1 if none.
    function automatic int ctl_slot(reg_ix_t ix);
        case (ix)
            IX_MEZ:  return 0;
            IX_CPUR: return 1;
            IX_PERR: return 2;
            IX_OPTA: return 3;
            IX_OPTB: return 4;
            IX_PMB:  return 5;
            default: return -1;
        endcase
    endfunction

endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/brd_spi_port.sv
module brd_spi_port
    import brd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk,
    input  logic    cs_n,
    input  logic    mosi,
    output logic    miso,
    output reg_ix_t rd_ix,
    input  byte_t   rd_data,
    output logic    wr_stb,
    output wr_req_t wr_req
);
    localparam int          BITS  = 2 * REG_W;
    localparam int          CW    = $clog2(BITS + 1);
    localparam logic [CW-1:0] C_ADDR = CW'(REG_W - 1);
    localparam logic [CW-1:0] C_LAST = CW'(BITS - 1);
    localparam logic [CW-1:0] C_BYTE = CW'(REG_W);
    localparam logic [CW-1:0] C_END  = CW'(BITS);

    logic s_cs, s_sclk, s_mosi, sclk_d;
    logic rise, fall;
    logic [CW-1:0] cnt;
    byte_t rx_sr, tx_sr, addr_q;
    logic  addr_stb, miso_q;
    spi_phase_e phase;

    brd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, mosi}),
        .q   ({s_cs, s_sclk, s_mosi})
    );

    assign rise  = s_sclk & ~sclk_d;
    assign fall  = ~s_sclk & sclk_d;
    assign phase = (cnt < C_BYTE) ? PH_ADDR : (cnt < C_END) ? PH_DATA : PH_DONE;

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b1;
        else     sclk_d <= s_sclk;
    end

    always_ff @(posedge clk) begin
        if (rst || s_cs) begin
            cnt      <= '0;
            tx_sr    <= '0;
            miso_q   <= 1'b0;
            addr_stb <= 1'b0;
            wr_stb   <= 1'b0;
            if (rst) begin
                rx_sr  <= '0;
                addr_q <= '0;
                wr_req <= '0;
            end
        end else begin
            addr_stb <= 1'b0;
            wr_stb   <= 1'b0;
            if (addr_stb) tx_sr <= addr_q[0] ? rd_data : '0;
            if (rise && phase != PH_DONE) begin
                rx_sr <= {rx_sr[REG_W-2:0], s_mosi};
                cnt   <= cnt + 1'b1;
                if (cnt == C_ADDR) begin
                    addr_q   <= {rx_sr[REG_W-2:0], s_mosi};
                    addr_stb <= 1'b1;
                end
                if (cnt == C_LAST && !addr_q[0]) begin
                    wr_stb       <= 1'b1;
                    wr_req.ix    <= addr_q[REG_W-1:1];
                    wr_req.data  <= {rx_sr[REG_W-2:0], s_mosi};
                end
            end else if (fall && phase == PH_DATA) begin
                miso_q <= tx_sr[REG_W-1];
                tx_sr  <= {tx_sr[REG_W-2:0], 1'b0};
            end
        end
    end

    assign rd_ix = addr_q[REG_W-1:1];
    assign miso  = miso_q;

    // R1
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({addr_stb, wr_stb}));

    // R11
    abort_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        s_cs |=> !wr_stb);

    // R2
    miso_addr_low_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ADDR) |=> !miso_q || $past(phase) != PH_ADDR);
endmodule

// File: rtl/brd_regfile.sv
module brd_regfile
    import brd_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter byte_t VERSION     = 8'h13,
    parameter byte_t WARM_KEY    = 8'hA5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  reg_ix_t                  rd_ix,
    output byte_t                    rd_data,
    input  logic                     wr_stb,
    input  wr_req_t                  wr_req,
    input  byte_t                    btn_s,
    input  byte_t                    pg_s [3],
    input  byte_t                    msel_s,
    output logic [3:0]               led_o,
    output logic [NUM_CTL*REG_W-1:0] ctl_o,
    output logic                     warm_rst_o
);
    localparam int AW = $clog2(SYNC_STAGES + 2);
    localparam logic [AW-1:0] ARM_N = AW'(SYNC_STAGES + 1);

    logic [3:0]  led_q;
    byte_t       ctl_q [NUM_CTL];
    byte_t       key_q, btn_d, flags_q, edge_v, clr_v;
    logic [AW-1:0] arm_cnt;
    logic        armed, warm_q;

    // Input change detection, held off until the synchronizer has filled.
    assign armed  = (arm_cnt == ARM_N);
    assign edge_v = armed ? (btn_s ^ btn_d) : '0;
    assign clr_v  = (wr_stb && wr_req.ix == IX_FLG) ? wr_req.data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            arm_cnt <= '0;
            btn_d   <= '0;
            flags_q <= '0;
        end else begin
            if (!armed) arm_cnt <= arm_cnt + 1'b1;
            btn_d   <= btn_s;
            flags_q <= (flags_q & ~clr_v) | edge_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            led_q  <= '0;
            key_q  <= '0;
            warm_q <= 1'b0;
        end else begin
            warm_q <= 1'b0;
            if (wr_stb) begin
                case (wr_req.ix)
                    IX_LED:  led_q <= wr_req.data[REG_W-1:REG_W-4];
                    IX_KEY:  key_q <= wr_req.data;
                    IX_WARM: begin
                        warm_q <= (key_q == WARM_KEY);
                        key_q  <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst)
                ctl_q[k] <= '0;
            else if (wr_stb && ctl_slot(wr_req.ix) == k)
                ctl_q[k] <= wr_req.data;
        end
        assign ctl_o[k*REG_W +: REG_W] = ctl_q[k];
    end

    always_comb begin
        case (rd_ix)
            IX_VER:  rd_data = VERSION;
            IX_LED:  rd_data = {led_q, 4'b0000};
            IX_BTN:  rd_data = btn_s;
            IX_FLG:  rd_data = flags_q;
            IX_PG0:  rd_data = pg_s[0];
            IX_PG1:  rd_data = pg_s[1];
            IX_PG2:  rd_data = pg_s[2];
            IX_MEZ:  rd_data = ctl_q[0];
            IX_CPUR: rd_data = ctl_q[1];
            IX_PERR: rd_data = ctl_q[2];
            IX_OPTA: rd_data = ctl_q[3];
            IX_OPTB: rd_data = ctl_q[4];
            IX_MSEL: rd_data = msel_s;
            IX_WARM: rd_data = '0;
            IX_KEY:  rd_data = key_q;
            IX_PMB:  rd_data = ctl_q[5];
            default: rd_data = '0;
        endcase
    end

    assign led_o      = led_q;
    assign warm_rst_o = warm_q;

    // R9
    warm_key_chk: assert property (@(posedge clk) disable iff (rst)
        warm_rst_o |-> $past(key_q) == WARM_KEY);

    // R9
    warm_single_chk: assert property (@(posedge clk) disable iff (rst)
        warm_rst_o |=> !warm_rst_o);

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|edge_v) |=> ((flags_q & $past(edge_v)) == $past(edge_v)));

    // R4
    led_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && wr_req.ix == IX_LED) |=> $stable(led_o));

    // R10
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_req.ix > IX_PMB) |=> $stable(ctl_o) && $stable(led_o) && $stable(key_q));
endmodule

// File: rtl/board_ctl_spi.sv
module board_ctl_spi
    import brd_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter byte_t VERSION     = 8'h13,
    parameter byte_t WARM_KEY    = 8'hA5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     mosi,
    output logic                     miso,
    output logic [3:0]               led_o,
    input  logic [REG_W-1:0]         btn_sw_i,
    input  logic [3*REG_W-1:0]       pwr_good_i,
    input  logic [REG_W-1:0]         mux_sel_i,
    output logic [NUM_CTL*REG_W-1:0] ctl_o,
    output logic                     warm_rst_o
);
    localparam int STAT_W = 5 * REG_W;

    reg_ix_t rd_ix;
    byte_t   rd_data, btn_s, msel_s;
    byte_t   pg_s [3];
    logic [3*REG_W-1:0] pg_flat;
    logic    wr_stb;
    wr_req_t wr_req;

    brd_sync #(.W(STAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_stat_sync (
        .clk (clk),
        .rst (rst),
        .d   ({mux_sel_i, pwr_good_i, btn_sw_i}),
        .q   ({msel_s, pg_flat, btn_s})
    );

    for (genvar p = 0; p < 3; p++) begin : g_pg
        assign pg_s[p] = pg_flat[p*REG_W +: REG_W];
    end

    brd_spi_port #(.SYNC_STAGES(SYNC_STAGES)) u_port (
        .clk     (clk),
        .rst     (rst),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .miso    (miso),
        .rd_ix   (rd_ix),
        .rd_data (rd_data),
        .wr_stb  (wr_stb),
        .wr_req  (wr_req)
    );

    brd_regfile #(
        .SYNC_STAGES (SYNC_STAGES),
        .VERSION     (VERSION),
        .WARM_KEY    (WARM_KEY)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rd_ix      (rd_ix),
        .rd_data    (rd_data),
        .wr_stb     (wr_stb),
        .wr_req     (wr_req),
        .btn_s      (btn_s),
        .pg_s       (pg_s),
        .msel_s     (msel_s),
        .led_o      (led_o),
        .ctl_o      (ctl_o),
        .warm_rst_o (warm_rst_o)
    );

    // R12
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (led_o == '0 && ctl_o == '0 && !warm_rst_o && !miso));
endmodule

// File: tb/board_ctl_spi_tb.sv
module board_ctl_spi_tb;
    localparam int HP = 6;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso, warm_rst_o;
    logic [3:0]  led_o;
    logic [7:0]  btn_sw_i = 8'h5A;
    logic [23:0] pwr_good_i = {8'hC3, 8'h81, 8'h7E};
    logic [7:0]  mux_sel_i = 8'h2D;
    logic [47:0] ctl_o;

    int errors = 0, checks = 0, pulses = 0, hi_cycles = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    board_ctl_spi u_dut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
        .led_o(led_o), .btn_sw_i(btn_sw_i), .pwr_good_i(pwr_good_i),
        .mux_sel_i(mux_sel_i), .ctl_o(ctl_o), .warm_rst_o(warm_rst_o)
    );

    always @(posedge clk) begin
        if (warm_rst_o) hi_cycles++;
        if (warm_rst_o && !$past(warm_rst_o)) pulses++;
    end

    // {is_read, address byte, write data, expected read}
    localparam logic [24:0] VEC [NV] = '{
        {1'b0, 8'h02, 8'hFF, 8'h00}, {1'b1, 8'h03, 8'h00, 8'hF0},
        {1'b1, 8'h01, 8'h00, 8'h13}, {1'b0, 8'h00, 8'h77, 8'h00},
        {1'b1, 8'h01, 8'h00, 8'h13}, {1'b0, 8'h04, 8'hFF, 8'h00},
        {1'b1, 8'h05, 8'h00, 8'h5A}, {1'b1, 8'h09, 8'h00, 8'h7E},
        {1'b1, 8'h0B, 8'h00, 8'h81}, {1'b1, 8'h0D, 8'h00, 8'hC3},
        {1'b0, 8'h18, 8'h00, 8'h00}, {1'b1, 8'h19, 8'h00, 8'h2D},
        {1'b0, 8'h0E, 8'h11, 8'h00}, {1'b0, 8'h1E, 8'h66, 8'h00},
        {1'b1, 8'h0F, 8'h00, 8'h11}, {1'b1, 8'h1F, 8'h00, 8'h66},
        {1'b0, 8'h40, 8'h99, 8'h00}, {1'b1, 8'h41, 8'h00, 8'h00},
        {1'b1, 8'h1B, 8'h00, 8'h00}, {1'b1, 8'h07, 8'h00, 8'h00}
    };

    function automatic string tag_for(logic [7:0] a);
        case (a[7:1])
            7'd0:  return "R3 R1 R2";
            7'd1:  return "R4 R1 R2";
            7'd2:  return "R5";
            7'd3:  return "R6";
            7'd4, 7'd5, 7'd6, 7'd12: return "R7";
            7'd13: return "R9";
            7'd7, 7'd15: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] d, input int nbits,
                        output logic [7:0] r);
        logic [15:0] sh;
        sh = {a, d};
        r  = '0;
        @(negedge clk) cs_n = 1'b0;
        repeat (HP) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = sh[15-i];
            repeat (HP) @(negedge clk);
            if (i >= 8) r = {r[6:0], miso};
            sclk = 1'b1;
            repeat (HP) @(negedge clk);
        end
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (2*HP) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] r;
        xfer(a, d, 16, r);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] r;
        xfer(a, 8'h00, 16, r);
        check(tag, {40'd0, r}, {40'd0, exp});
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R12 reset state
        check("R12 led", {44'd0, led_o}, 48'd0);
        check("R12 ctl", ctl_o, 48'd0);
        check("R12 miso/warm", {46'd0, miso, warm_rst_o}, 48'd0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check("R12 after release", {miso, warm_rst_o, led_o, ctl_o[41:0]}, 48'd0);

        for (int v = 0; v < NV; v++) begin
            logic [7:0] r;
            xfer(VEC[v][23:16], VEC[v][15:8], 16, r);
            if (VEC[v][24])
                check(tag_for(VEC[v][23:16]), {40'd0, r}, {40'd0, VEC[v][7:0]});
        end
        check("R4 led pins", {44'd0, led_o}, 48'hF);
        check("R8 ctl bytes", ctl_o, {8'h66, 32'd0, 8'h11});

        // R11 abort after twelve bits
        begin
            logic [7:0] r;
            xfer(8'h0E, 8'hEE, 12, r);
        end
        check("R11 ctl after abort", ctl_o, {8'h66, 32'd0, 8'h11});
        rd_chk("R11 readback", 8'h0F, 8'h11);

        // R6 flags
        @(negedge clk) btn_sw_i = 8'h5B;
        repeat (10) @(negedge clk);
        rd_chk("R6 set bit0", 8'h07, 8'h01);
        wr(8'h06, 8'h00);
        rd_chk("R6 zero write keeps", 8'h07, 8'h01);
        wr(8'h06, 8'h01);
        rd_chk("R6 cleared", 8'h07, 8'h00);
        @(negedge clk) btn_sw_i = 8'h7B;
        repeat (4) @(negedge clk);
        btn_sw_i = 8'h5B;
        repeat (10) @(negedge clk);
        rd_chk("R6 pulse caught", 8'h07, 8'h20);
        rd_chk("R5 live level", 8'h05, 8'h5B);

        // R9 warm reset guard
        wr(8'h1A, 8'h01);
        check("R9 no key no pulse", pulses, 0);
        wr(8'h1C, 8'hA5);
        rd_chk("R9 key readback", 8'h1D, 8'hA5);
        wr(8'h1A, 8'h01);
        check("R9 pulse", pulses, 1);
        check("R9 width", hi_cycles, 1);
        rd_chk("R9 key cleared", 8'h1D, 8'h00);
        wr(8'h1A, 8'h01);
        check("R9 consumed key", pulses, 1);
        wr(8'h1C, 8'h5A);
        wr(8'h1A, 8'h01);
        check("R9 wrong key", pulses, 1);
        rd_chk("R9 wrong key cleared", 8'h1D, 8'h00);

        // R10 writes beyond the map
        wr(8'h7E, 8'hFF);
        check("R10 ctl untouched", ctl_o, {8'h66, 32'd0, 8'h11});
        check("R10 led untouched", {44'd0, led_o}, 48'hF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule